// File: doc/BRIEF.md
# Cache Flush and Invalidate Sequencer

This controller sits next to a secondary cache tag store and walks its entries, one index at a time, to write dirty lines back or to wipe the whole store. A two-bit command input selects the job. Code 00 means do nothing. Code 01 selects a page flush, code 10 a whole-cache flush and code 11 an invalidate of every line. A busy output covers the whole job. A page register captures the page number on every cache-inhibited write, so the most recent such write before the command names the page that a page flush visits.

A flush is coherent. For each index the controller reads the main tag (valid and modified bits) and the primary-side inclusion bit through a combinational read port. A clean line is skipped. A dirty line whose inclusion bit is set first gets a primary invalidate request. If the primary answers with newer data, the secondary line is refreshed and the inclusion bit is cleared. The line is then written back to memory and its modified bit is cleared. Snoops are still accepted while a flush runs, but only between steps, and processor requests are not held. The invalidate is not coherent. It clears every valid bit and every inclusion bit, one index per clock, while snoops are refused and the processor is stalled.

Top module: `flush_seq`

## Requirements
- R1: After reset, busy, pinvReq, cbReq and procStall are low. A command code other than 00 seen on cmd for one clock starts a job when the command is armed, and busy is high from the next clock on.
- R2: Once a job has started, cmd is ignored until the job completes and cmd has returned to 00. A non-zero code held past completion does not start a second job.
- R3: busy falls on the clock that finishes the last index. On an array with no modified line, a whole-cache flush keeps busy high for exactly DEPTH clocks and a page flush for exactly 2^SET_W clocks.
- R4: A whole-cache flush (code 10) visits indices 0 up to DEPTH-1 in ascending order, whatever page is latched.
- R5: A page flush (code 01) visits indices {page, set} for set 0 up to 2^SET_W-1 in ascending order. Here page is the value of ciPage at the last ciWrite before the command. Lines outside that page are not touched.
- R6: During a flush, a line that is not both valid and modified causes no request and keeps all of its tag bits.
- R7: A modified line with its inclusion bit set gets a primary invalidate first and then a copyback. A pinvDirty answer raises lineUpdate and clears the inclusion bit. The completed copyback clears the modified bit. pinvReq and cbReq are never high together.
- R8: A modified line whose inclusion bit is clear gets only a copyback, with no primary invalidate. Its modified bit is cleared.
- R9: An invalidate (code 11) clears every valid and every inclusion bit and leaves the modified bits as they were. It holds busy high for exactly DEPTH clocks. During it, procStall is high and snoopGrant stays low.
- R10: Outside an invalidate, procStall is low and snoopReq is granted. During a flush, a grant happens only at the start of a step, never while a request is outstanding.
- R11: pinvReq and cbReq stay high until their acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Job code: 00 none, 01 page flush, 10 whole flush, 11 invalidate |
| ciWrite | input | 1 | Cache-inhibited write strobe, loads the page register |
| ciPage | input | IDX_W-SET_W | Page number carried by the cache-inhibited write |
| busy | output | 1 | A job is in progress |
| tagIdx | output | IDX_W | Index presented to the tag arrays |
| tagValid | input | 1 | Valid bit of the main tag at tagIdx |
| tagModified | input | 1 | Modified bit of the main tag at tagIdx |
| primIncl | input | 1 | Inclusion bit of the primary-side tag at tagIdx |
| tagClrValid | output | 1 | Clear the valid bit at tagIdx on this edge |
| tagClrModified | output | 1 | Clear the modified bit at tagIdx on this edge |
| primClrIncl | output | 1 | Clear the inclusion bit at tagIdx on this edge |
| lineUpdate | output | 1 | Write newer primary data into the secondary line at tagIdx |
| pinvReq | output | 1 | Primary invalidate request |
| pinvAck | input | 1 | Primary invalidate acknowledge |
| pinvDirty | input | 1 | The primary answered with newer data (valid with pinvAck) |
| cbReq | output | 1 | Memory copyback request |
| cbAck | input | 1 | Copyback acknowledge |
| snoopReq | input | 1 | A snoop wants the tag store |
| snoopGrant | output | 1 | The snoop is accepted in this clock |
| procStall | output | 1 | Hold off processor requests |

## Verification
The bench tries a page flush on the first page, a middle page and the last page, each after a decoy cache-inhibited write. A design that kept the first page it latched, or that walked past the set boundary, would damage lines outside the page. Clean arrays are flushed and busy is timed to the clock, so a walk that spends extra cycles per index, or stops one index early or late, is caught. A command held past completion and then dropped and reissued shows whether the design re-arms only through 00. Snoops are raised while requests wait on slow acknowledges and again during an invalidate, which would expose a grant that cuts into a step or a lockout that leaks.

// File: rtl/flush_seq_pkg.sv
package flush_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PAGE = 2'b01,
    CMD_ALL  = 2'b10,
    CMD_INV  = 2'b11
  } cmd_e;

  // strobes from the control FSM to the walk datapath
  typedef struct packed {
    logic load;     // start a walk, pick its first index
    logic step;     // move to the next index
    logic pageSel;  // with load: restrict the walk to the latched page
  } walk_strobe_t;
endpackage

// File: rtl/flush_seq_walk.sv
module flush_seq_walk
  import flush_seq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int SET_W = 3,
  localparam int PAGE_W = IDX_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  walk_strobe_t      strobe,
  input  logic              ciWrite,
  input  logic [PAGE_W-1:0] ciPage,
  output logic [IDX_W-1:0]  tagIdx,
  output logic              isLast
);
  logic [PAGE_W-1:0] pageLatch;
  logic [IDX_W-1:0]  idx;
  logic              pageMode;

  // page register: every cache-inhibited write overwrites it
  always_ff @(posedge clk) begin
    if (!rstN)        pageLatch <= '0;
    else if (ciWrite) pageLatch <= ciPage;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      pageMode <= 1'b0;
    end else if (strobe.load) begin
      pageMode <= strobe.pageSel;
      idx      <= strobe.pageSel ? {pageLatch, {SET_W{1'b0}}} : '0;
    end else if (strobe.step) begin
      idx <= idx + 1'b1;
    end
  end

  assign tagIdx = idx;
  assign isLast = pageMode ? (&idx[SET_W-1:0]) : (&idx);
endmodule

// File: rtl/flush_seq_ctrl.sv
module flush_seq_ctrl
  import flush_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   cmd,
  input  logic         tagValid,
  input  logic         tagModified,
  input  logic         primIncl,
  input  logic         isLast,
  input  logic         pinvAck,
  input  logic         pinvDirty,
  input  logic         cbAck,
  input  logic         snoopReq,
  output walk_strobe_t strobe,
  output logic         busy,
  output logic         pinvReq,
  output logic         cbReq,
  output logic         tagClrValid,
  output logic         tagClrModified,
  output logic         primClrIncl,
  output logic         lineUpdate,
  output logic         snoopGrant,
  output logic         procStall
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_PINV, S_CB, S_INV} state_e;

  state_e state, stateNext;
  logic   armed;
  logic   start;

  assign start = (state == S_IDLE) && armed && (cmd != CMD_NOP);

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    pinvReq        = 1'b0;
    cbReq          = 1'b0;
    tagClrValid    = 1'b0;
    tagClrModified = 1'b0;
    primClrIncl    = 1'b0;
    lineUpdate     = 1'b0;
    snoopGrant     = 1'b0;
    procStall      = 1'b0;
    case (state)
      S_IDLE: begin
        snoopGrant = snoopReq;
        if (start) begin
          strobe.load    = 1'b1;
          strobe.pageSel = (cmd == CMD_PAGE);
          stateNext      = (cmd == CMD_INV) ? S_INV : S_CHECK;
        end
      end
      S_CHECK: begin
        if (snoopReq) begin
          snoopGrant = 1'b1;  // served before this step begins
        end else if (tagValid && tagModified) begin
          stateNext = primIncl ? S_PINV : S_CB;
        end else if (isLast) begin
          stateNext = S_IDLE;
        end else begin
          strobe.step = 1'b1;
        end
      end
      S_PINV: begin
        pinvReq = 1'b1;
        if (pinvAck) begin
          if (pinvDirty) begin
            lineUpdate  = 1'b1;
            primClrIncl = 1'b1;
          end
          stateNext = S_CB;
        end
      end
      S_CB: begin
        cbReq = 1'b1;
        if (cbAck) begin
          tagClrModified = 1'b1;
          if (isLast) stateNext = S_IDLE;
          else begin
            strobe.step = 1'b1;
            stateNext   = S_CHECK;
          end
        end
      end
      S_INV: begin
        procStall   = 1'b1;
        tagClrValid = 1'b1;
        primClrIncl = 1'b1;
        if (isLast) stateNext = S_IDLE;
        else        strobe.step = 1'b1;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      armed <= 1'b0;
    end else begin
      state <= stateNext;
      if (start)                armed <= 1'b0;
      else if (cmd == CMD_NOP)  armed <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/flush_seq.sv
module flush_seq
  import flush_seq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int SET_W = 3,
  localparam int PAGE_W = IDX_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic              ciWrite,
  input  logic [PAGE_W-1:0] ciPage,
  output logic              busy,
  output logic [IDX_W-1:0]  tagIdx,
  input  logic              tagValid,
  input  logic              tagModified,
  input  logic              primIncl,
  output logic              tagClrValid,
  output logic              tagClrModified,
  output logic              primClrIncl,
  output logic              lineUpdate,
  output logic              pinvReq,
  input  logic              pinvAck,
  input  logic              pinvDirty,
  output logic              cbReq,
  input  logic              cbAck,
  input  logic              snoopReq,
  output logic              snoopGrant,
  output logic              procStall
);
  walk_strobe_t strobe;
  logic         isLast;

  flush_seq_walk #(.IDX_W(IDX_W), .SET_W(SET_W)) uWalk (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ciWrite(ciWrite),
    .ciPage(ciPage), .tagIdx(tagIdx), .isLast(isLast)
  );

  flush_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .tagValid(tagValid),
    .tagModified(tagModified), .primIncl(primIncl), .isLast(isLast),
    .pinvAck(pinvAck), .pinvDirty(pinvDirty), .cbAck(cbAck),
    .snoopReq(snoopReq), .strobe(strobe), .busy(busy), .pinvReq(pinvReq),
    .cbReq(cbReq), .tagClrValid(tagClrValid), .tagClrModified(tagClrModified),
    .primClrIncl(primClrIncl), .lineUpdate(lineUpdate),
    .snoopGrant(snoopGrant), .procStall(procStall)
  );
endmodule

// File: rtl/flush_seq_checker.sv
module flush_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] cmd,
  input logic       busy,
  input logic       pinvReq,
  input logic       pinvAck,
  input logic       pinvDirty,
  input logic       cbReq,
  input logic       cbAck,
  input logic       snoopGrant,
  input logic       procStall,
  input logic       lineUpdate
);
  assert_busy_follows_cmd_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(cmd) != 2'b00));

  assert_pinv_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pinvReq && !pinvAck) |=> pinvReq);

  assert_cb_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cbReq && !cbAck) |=> cbReq);

  assert_single_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(pinvReq && cbReq));

  assert_update_on_dirty_R7: assert property (@(posedge clk) disable iff (!rstN)
    lineUpdate |-> (pinvReq && pinvAck && pinvDirty));

  assert_lockout_R9: assert property (@(posedge clk) disable iff (!rstN)
    procStall |-> (busy && !snoopGrant));

  assert_snoop_between_steps_R10: assert property (@(posedge clk) disable iff (!rstN)
    snoopGrant |-> (!pinvReq && !cbReq));
endmodule

bind flush_seq flush_seq_checker uChk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .busy(busy), .pinvReq(pinvReq),
  .pinvAck(pinvAck), .pinvDirty(pinvDirty), .cbReq(cbReq), .cbAck(cbAck),
  .snoopGrant(snoopGrant), .procStall(procStall), .lineUpdate(lineUpdate)
);

// File: tb/flush_seq_test.sv
module flush_seq_test;
  localparam int IDX_W  = 6;
  localparam int SET_W  = 3;
  localparam int PAGE_W = IDX_W - SET_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int SETS   = 1 << SET_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic ciWrite = 1'b0;
  logic [PAGE_W-1:0] ciPage = '0;
  logic busy;
  logic [IDX_W-1:0] tagIdx;
  logic tagValid, tagModified, primIncl;
  logic tagClrValid, tagClrModified, primClrIncl, lineUpdate;
  logic pinvReq, cbReq, snoopGrant, procStall;
  logic pinvAck = 1'b0, pinvDirty = 1'b0, cbAck = 1'b0, snoopReq = 1'b0;

  always #4 clk = ~clk;

  flush_seq #(.IDX_W(IDX_W), .SET_W(SET_W)) uut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ciWrite(ciWrite), .ciPage(ciPage),
    .busy(busy), .tagIdx(tagIdx), .tagValid(tagValid), .tagModified(tagModified),
    .primIncl(primIncl), .tagClrValid(tagClrValid), .tagClrModified(tagClrModified),
    .primClrIncl(primClrIncl), .lineUpdate(lineUpdate), .pinvReq(pinvReq),
    .pinvAck(pinvAck), .pinvDirty(pinvDirty), .cbReq(cbReq), .cbAck(cbAck),
    .snoopReq(snoopReq), .snoopGrant(snoopGrant), .procStall(procStall)
  );

  // tag arrays
  logic vArr [DEPTH];
  logic mArr [DEPTH];
  logic iArr [DEPTH];
  logic eV [DEPTH];
  logic eM [DEPTH];
  logic eI [DEPTH];

  assign tagValid    = vArr[tagIdx];
  assign tagModified = mArr[tagIdx];
  assign primIncl    = iArr[tagIdx];

  int nChecks = 0, nFails = 0;
  int cbCnt = 0, pinvCnt = 0, updCnt = 0, orderBad = 0, dropBad = 0;
  int lastCb = -1;
  int stallSeen = 0;
  int pCnt = 0, cCnt = 0;
  logic prevPinv = 1'b0, prevCb = 1'b0, prevPAck = 1'b0, prevCAck = 1'b0;
  bit done = 0;

  function automatic logic dirtyOf(int i);
    return logic'(((i & 1) != 0) ^ ((i & 4) != 0));
  endfunction

  always @(posedge clk) begin
    if (tagClrValid)    vArr[tagIdx] <= 1'b0;
    if (tagClrModified) mArr[tagIdx] <= 1'b0;
    if (primClrIncl)    iArr[tagIdx] <= 1'b0;
    if (lineUpdate) updCnt++;
    if (pinvReq && pinvAck) pinvCnt++;
    if (cbReq && cbAck) begin
      cbCnt++;
      if (int'(tagIdx) <= lastCb) orderBad++;
      lastCb = int'(tagIdx);
    end
    if (procStall) stallSeen++;
    if ((prevPinv && !prevPAck && !pinvReq) || (prevCb && !prevCAck && !cbReq)) dropBad++;
    prevPinv = pinvReq; prevCb = cbReq; prevPAck = pinvAck; prevCAck = cbAck;
  end

  // slow responders: delay depends on the index
  always @(negedge clk) begin
    if (pinvAck) pinvAck = 1'b0;
    else if (pinvReq) begin
      if (pCnt >= int'(tagIdx) % 3) begin
        pinvAck = 1'b1; pinvDirty = dirtyOf(int'(tagIdx)); pCnt = 0;
      end else pCnt++;
    end
    if (cbAck) cbAck = 1'b0;
    else if (cbReq) begin
      if (cCnt >= (int'(tagIdx) + 1) % 3) begin cbAck = 1'b1; cCnt = 0; end
      else cCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic fillArrays(input int pat);
    for (int i = 0; i < DEPTH; i++) begin
      int h;
      h = (i * 5 + pat * 3) & 7;
      vArr[i] = (h != 0) && (h != 4);
      mArr[i] = vArr[i] && ((h & 1) != 0);
      iArr[i] = (h & 2) != 0;
      if (pat == 15) begin vArr[i] = 1'b1; mArr[i] = 1'b0; iArr[i] = 1'b1; end
    end
  endtask

  task automatic clearStats();
    cbCnt = 0; pinvCnt = 0; updCnt = 0; orderBad = 0; dropBad = 0;
    lastCb = -1; stallSeen = 0;
  endtask

  task automatic doCiWrite(input int p);
    @(negedge clk); ciWrite = 1'b1; ciPage = PAGE_W'(p);
    @(negedge clk); ciWrite = 1'b0;
  endtask

  task automatic runCmd(input logic [1:0] c, output int busyCyc);
    @(negedge clk); cmd = c;
    @(negedge clk); cmd = 2'b00;
    busyCyc = 0;
    while (busy && busyCyc < 20000) begin busyCyc++; @(negedge clk); end
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic [3:0] page;
    logic [3:0] decoy;
    logic [3:0] pat;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b10, 4'd5, 4'd1, 4'd3},
    '{2'b01, 4'd2, 4'd6, 4'd1},
    '{2'b01, 4'd7, 4'd0, 4'd6},
    '{2'b01, 4'd0, 4'd3, 4'd2},
    '{2'b11, 4'd4, 4'd2, 4'd5},
    '{2'b10, 4'd0, 4'd7, 4'd4},
    '{2'b01, 4'd4, 4'd5, 4'd7}
  };

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int cyc, eCb, ePinv, eUpd, bad, lo, hi, grants, grantBad, tries;
    fillArrays(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !pinvReq && !cbReq && !procStall, "R1 reset outputs",
          int'({busy, pinvReq, cbReq, procStall}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table of vectors
    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      fillArrays(int'(v.pat));
      clearStats();
      doCiWrite(int'(v.decoy));
      doCiWrite(int'(v.page));
      eCb = 0; ePinv = 0; eUpd = 0;
      lo = (v.op == 2'b01) ? int'(v.page) * SETS : 0;
      hi = (v.op == 2'b01) ? lo + SETS - 1 : DEPTH - 1;
      for (int i = 0; i < DEPTH; i++) begin
        eV[i] = vArr[i]; eM[i] = mArr[i]; eI[i] = iArr[i];
        if (v.op == 2'b11) begin
          eV[i] = 1'b0; eI[i] = 1'b0;
        end else if (i >= lo && i <= hi && vArr[i] && mArr[i]) begin
          eCb++;
          if (iArr[i]) begin
            ePinv++;
            if (dirtyOf(i)) begin eUpd++; eI[i] = 1'b0; end
          end
          eM[i] = 1'b0;
        end
      end
      runCmd(v.op, cyc);
      bad = 0;
      for (int i = 0; i < DEPTH; i++)
        if (vArr[i] != eV[i] || mArr[i] != eM[i] || iArr[i] != eI[i]) bad++;
      if (v.op == 2'b11) begin
        check(bad == 0, "R9 invalidate tag state", bad, 0);
        check(cyc == DEPTH, "R9 invalidate length", cyc, DEPTH);
        check(cbCnt == 0 && pinvCnt == 0, "R9 no requests", cbCnt + pinvCnt, 0);
      end else begin
        check(bad == 0, (v.op == 2'b01) ? "R5 page flush tag state" : "R4 full flush tag state", bad, 0);
        check(cbCnt == eCb, "R8 copyback count", cbCnt, eCb);
        check(pinvCnt == ePinv, "R7 primary invalidate count", pinvCnt, ePinv);
        check(updCnt == eUpd, "R7 line update count", updCnt, eUpd);
        check(orderBad == 0, "R4 ascending walk", orderBad, 0);
        check(stallSeen == 0, "R10 no stall during flush", stallSeen, 0);
        check(dropBad == 0, "R11 request held to ack", dropBad, 0);
      end
    end

    // R3/R6 clean arrays: one clock per index
    fillArrays(15);
    clearStats();
    runCmd(2'b10, cyc);
    check(cyc == DEPTH, "R3 clean full flush length", cyc, DEPTH);
    check(cbCnt == 0 && pinvCnt == 0, "R6 clean lines no requests", cbCnt + pinvCnt, 0);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (!vArr[i] || mArr[i] || !iArr[i]) bad++;
    check(bad == 0, "R6 clean lines untouched", bad, 0);
    doCiWrite(3);
    runCmd(2'b01, cyc);
    check(cyc == SETS, "R3 clean page flush length", cyc, SETS);

    // R1 busy timing, R2 rearm
    @(negedge clk); cmd = 2'b11;
    #1 check(!busy, "R1 busy low in command clock", int'(busy), 0);
    @(negedge clk);
    check(busy, "R1 busy one clock later", int'(busy), 1);
    cyc = 0;
    while (busy && cyc < 20000) begin cyc++; @(negedge clk); end
    repeat (5) @(negedge clk);
    check(!busy, "R2 held command not rearmed", int'(busy), 0);
    cmd = 2'b00;
    @(negedge clk); cmd = 2'b11;
    @(negedge clk); cmd = 2'b00;
    check(busy, "R2 rearmed after idle code", int'(busy), 1);
    while (busy) @(negedge clk);

    // R9 lockout during invalidate
    snoopReq = 1'b1;
    @(negedge clk); cmd = 2'b11;
    @(negedge clk); cmd = 2'b00;
    grants = 0; bad = 0;
    while (busy) begin
      #1 if (snoopGrant) grants++;
      if (!procStall) bad++;
      @(negedge clk);
    end
    check(grants == 0, "R9 snoop refused during invalidate", grants, 0);
    check(bad == 0, "R9 processor stalled during invalidate", bad, 0);
    #1 check(snoopGrant, "R10 idle snoop granted", int'(snoopGrant), 1);
    snoopReq = 1'b0;

    // R10 snoops during a flush with slow acknowledges
    fillArrays(3);
    clearStats();
    @(negedge clk); cmd = 2'b10;
    @(negedge clk); cmd = 2'b00;
    grants = 0; grantBad = 0; tries = 0;
    while (busy && tries < 20000) begin
      tries++;
      snoopReq = (tries % 4) == 0;
      #1 if (snoopGrant) begin
        grants++;
        if (pinvReq || cbReq) grantBad++;
      end
      @(negedge clk);
      snoopReq = 1'b0;
    end
    check(grants > 0, "R10 snoops granted during flush", grants, 1);
    check(grantBad == 0, "R10 grant only between steps", grantBad, 0);
    check(stallSeen == 0, "R10 processor not stalled", stallSeen, 0);

    finishRun();
  end
endmodule